// File: doc/BRIEF.md
# Packet Thread Chain Scheduler

This block schedules the hardware threads of one packet-processing core. The threads form a pipeline: a packet enters at thread 0, is worked on by each thread in turn and leaves after the last one. The core has one execution slot. The scheduler keeps a status for every thread, decides which thread owns the slot, moves packets from one thread to the next, and keeps an in-order list of the memory accesses that threads are waiting on.

Each thread runs a small state machine with five states. `TS_IDLE` means the thread has no packet. `TS_ACTIVE` means it holds the slot. `TS_MEMWAIT` means it is waiting on a memory access. `TS_READY` means it holds a packet and waits for the slot. `TS_BLOCKED` means it has finished its packet but cannot pass it on because its successor is busy.

The transitions are these:
- idle to active or ready, when a packet arrives or is handed over.
- active to memwait, on a memory request.
- active to idle, on a done strobe with a free successor.
- active to blocked, on a done strobe with a busy successor.
- active to active or ready, when the thread passes its packet and takes a new one in the same cycle.
- memwait to ready or active, when the access completes.
- ready to active, when the thread is granted the slot.
- blocked to idle, or blocked to ready or active, when its successor passes its packet on.

Top module: `pkt_thread_sched`

## Requirements
- R1: Status field j of `thr_status` sits at bits [3j+2:3j] and uses these codes: 0 idle, 1 active, 2 memwait, 3 ready, 4 blocked. After reset every thread is idle and every output is 0, and `act_tid` reads 0 whenever `act_valid` is 0.
- R2: At most one thread is active in any cycle. `act_valid` and `act_tid` report that thread.
- R3: No thread is ready in a cycle where no thread is active. When the slot is vacated or is empty, a waiting thread takes it at the same edge.
- R4: An arrival is accepted only if thread 0 is idle. In that case `pkt_accept` pulses one cycle later, and thread 0 becomes active if the slot is free, otherwise ready. A refused arrival changes nothing.
- R5: A memory request from the active thread moves it to memwait and pulses `mem_issue` with its index one cycle later. If done and memory request are given together, done wins.
- R6: A completion is taken only if its index equals the oldest outstanding request. The thread then becomes ready, or active if the slot is free. A completion with any other index is ignored.
- R7: A done strobe on the active thread passes its packet on when the thread is the last one or its successor is idle. The successor becomes ready or active, and when the last thread passes its packet, `chain_exit` pulses one cycle later.
- R8: A done strobe with a non-idle successor blocks the thread. The last thread is never blocked, and a blocked thread never has an idle successor.
- R9: When a thread passes its packet on, the contiguous run of blocked threads directly upstream of it releases in the same cycle. Every thread in the run passes its packet down, and the lowest thread of the run becomes idle unless a new packet is accepted into it.
- R10: Candidates for the slot are searched round-robin, starting at the index after the last active thread and wrapping, so the thread that just left the slot has the lowest priority. After reset the search starts at thread 0.
- R11: Done and memory-request strobes of threads that are not active have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_arrive | input | 1 | Packet offered to thread 0 |
| mem_req | input | NTHR | Per-thread memory request strobe |
| proc_done | input | NTHR | Per-thread processing-complete strobe |
| mem_cpl_valid | input | 1 | Memory completion valid |
| mem_cpl_tid | input | TIDW | Thread index of the completion |
| thr_status | output | 3*NTHR | Packed per-thread status codes |
| act_valid | output | 1 | A thread holds the slot |
| act_tid | output | TIDW | Index of the active thread |
| pkt_accept | output | 1 | Arrival was taken (one-cycle pulse) |
| chain_exit | output | 1 | Last thread passed its packet out (pulse) |
| mem_issue | output | 1 | New memory request issued (pulse) |
| mem_issue_tid | output | TIDW | Thread index of the issued request |

## Verification
Every status change, every grant and every pulse (`pkt_accept`, `chain_exit`, `mem_issue`) is registered at the clock edge that samples the stimulus. Each result can therefore be seen exactly one cycle after the stimulus is applied. The bench drives a stimulus on a falling edge and queues the expected snapshot. It then compares the outputs a quarter-period after the next rising edge, so each comparison falls in the cycle right after its stimulus. The expected status vectors come from hand-worked sequences of hand-off, blocking, cascade release, refusal and round-robin cases.

// File: rtl/tsched_pkg.sv
package tsched_pkg;

    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        TS_IDLE    = 3'd0,
        TS_ACTIVE  = 3'd1,
        TS_MEMWAIT = 3'd2,
        TS_READY   = 3'd3,
        TS_BLOCKED = 3'd4
    } thr_state_e;

endpackage

// File: rtl/tsched_rr_pick.sv
module tsched_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          en,
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] last_idx,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx,
    output logic [N-1:0]  gnt_vec
);

    always_comb begin
        int pos;
        logic found;
        found = 1'b0;
        pos   = 0;
        for (int k = 1; k <= N; k++) begin
            int probe;
            probe = (int'(last_idx) + k) % N;
            if (!found && cand[probe]) begin
                found = 1'b1;
                pos   = probe;
            end
        end
        gnt_valid = en && found;
        gnt_idx   = IW'(pos);
        gnt_vec   = '0;
        if (gnt_valid) begin
            gnt_vec[pos] = 1'b1;
        end
    end

endmodule

// File: rtl/tsched_memq.sv
module tsched_memq #(
    parameter int DEPTH = 4,
    parameter int IW    = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic          pop,
    output logic [IW-1:0] head_idx,
    output logic          empty
);

    logic [IW-1:0] slot_q [DEPTH];
    logic [PW-1:0] wr_ptr_q;
    logic [PW-1:0] rd_ptr_q;
    logic [PW:0]   cnt_q;
    logic          full;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == (PW+1)'(DEPTH));
    assign head_idx = slot_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= bump(wr_ptr_q);
            end
            if (pop) begin
                rd_ptr_q <= bump(rd_ptr_q);
            end
            if (push && !pop) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (pop && !push) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[wr_ptr_q] <= push_idx;
        end
    end

    // R6: completions are taken only against an outstanding entry
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R5: a thread can hold at most one outstanding access
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/tsched_thread.sv
module tsched_thread
    import tsched_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_done,
    input  logic       ev_mem,
    input  logic       rel_self,
    input  logic       gets_pkt,
    input  logic       mem_back,
    input  logic       grant,
    output thr_state_e st_q,
    output logic       want
);

    thr_state_e st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= TS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_IDLE: begin
                if (gets_pkt) begin
                    st_d = grant ? TS_ACTIVE : TS_READY;
                end
            end
            TS_ACTIVE: begin
                if (ev_done) begin
                    if (!rel_self) begin
                        st_d = TS_BLOCKED;
                    end else if (gets_pkt) begin
                        st_d = grant ? TS_ACTIVE : TS_READY;
                    end else begin
                        st_d = TS_IDLE;
                    end
                end else if (ev_mem) begin
                    st_d = TS_MEMWAIT;
                end
            end
            TS_MEMWAIT: begin
                if (mem_back) begin
                    st_d = grant ? TS_ACTIVE : TS_READY;
                end
            end
            TS_READY: begin
                if (grant) begin
                    st_d = TS_ACTIVE;
                end
            end
            TS_BLOCKED: begin
                if (rel_self) begin
                    if (gets_pkt) begin
                        st_d = grant ? TS_ACTIVE : TS_READY;
                    end else begin
                        st_d = TS_IDLE;
                    end
                end
            end
            default: st_d = TS_IDLE;
        endcase
    end

    // candidacy for the execution slot
    always_comb begin
        want = 1'b0;
        unique case (st_q)
            TS_IDLE:    want = gets_pkt;
            TS_ACTIVE:  want = ev_done && rel_self && gets_pkt;
            TS_MEMWAIT: want = mem_back;
            TS_READY:   want = 1'b1;
            TS_BLOCKED: want = rel_self && gets_pkt;
            default:    want = 1'b0;
        endcase
    end

endmodule

// File: rtl/pkt_thread_sched.sv
module pkt_thread_sched
    import tsched_pkg::*;
#(
    parameter int NTHR       = 4,
    parameter int MEMQ_DEPTH = NTHR,
    localparam int TIDW      = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pkt_arrive,
    input  logic [NTHR-1:0]      mem_req,
    input  logic [NTHR-1:0]      proc_done,
    input  logic                 mem_cpl_valid,
    input  logic [TIDW-1:0]      mem_cpl_tid,
    output logic [NTHR*ST_W-1:0] thr_status,
    output logic                 act_valid,
    output logic [TIDW-1:0]      act_tid,
    output logic                 pkt_accept,
    output logic                 chain_exit,
    output logic                 mem_issue,
    output logic [TIDW-1:0]      mem_issue_tid
);

    thr_state_e      st [NTHR];
    logic [NTHR-1:0] act_vec, rdy_vec, blk_vec;
    logic [NTHR-1:0] ev_done, ev_mem, hand_ok, rel, gets, mem_back;
    logic [NTHR-1:0] want, grant;
    logic            accept, leave, slot_free, cpl_take, q_empty;
    logic [TIDW-1:0] q_head, last_q, gnt_idx;
    logic            gnt_valid;
    logic            acc_q, exit_q, mi_q;
    logic [TIDW-1:0] mit_q;

    // status views
    always_comb begin
        for (int j = 0; j < NTHR; j++) begin
            act_vec[j] = (st[j] == TS_ACTIVE);
            rdy_vec[j] = (st[j] == TS_READY);
            blk_vec[j] = (st[j] == TS_BLOCKED);
            thr_status[j*ST_W +: ST_W] = st[j];
        end
    end

    always_comb begin
        act_valid = 1'b0;
        act_tid   = '0;
        for (int j = 0; j < NTHR; j++) begin
            if (act_vec[j] && !act_valid) begin
                act_valid = 1'b1;
                act_tid   = TIDW'(j);
            end
        end
    end

    // activator events: only the active thread's strobes count
    assign ev_done = act_vec & proc_done;
    assign ev_mem  = act_vec & mem_req & ~proc_done;
    assign accept  = pkt_arrive && (st[0] == TS_IDLE);
    assign leave   = |(ev_done | ev_mem);
    assign slot_free = !act_valid || leave;

    // hand-off permission per thread
    for (genvar g = 0; g < NTHR; g++) begin : g_hand
        if (g == NTHR - 1) begin : g_last
            assign hand_ok[g] = 1'b1;
        end else begin : g_mid
            assign hand_ok[g] = (st[g+1] == TS_IDLE);
        end
    end

    // release chain: a hand-off frees the blocked run just upstream
    always_comb begin
        rel[NTHR-1] = ev_done[NTHR-1];
        for (int j = NTHR - 2; j >= 0; j--) begin
            rel[j] = (ev_done[j] && hand_ok[j]) || (blk_vec[j] && rel[j+1]);
        end
    end

    for (genvar g = 0; g < NTHR; g++) begin : g_gets
        if (g == 0) begin : g_first
            assign gets[g] = accept;
        end else begin : g_next
            assign gets[g] = rel[g-1];
        end
    end

    // memory tracking
    assign cpl_take = mem_cpl_valid && !q_empty && (mem_cpl_tid == q_head);

    for (genvar g = 0; g < NTHR; g++) begin : g_mback
        assign mem_back[g] = cpl_take && (q_head == TIDW'(g));
    end

    tsched_memq #(
        .DEPTH (MEMQ_DEPTH),
        .IW    (TIDW)
    ) i_memq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (|ev_mem),
        .push_idx (act_tid),
        .pop      (cpl_take),
        .head_idx (q_head),
        .empty    (q_empty)
    );

    tsched_rr_pick #(
        .N  (NTHR),
        .IW (TIDW)
    ) i_pick (
        .en        (slot_free),
        .cand      (want),
        .last_idx  (last_q),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .gnt_vec   (grant)
    );

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        tsched_thread i_thr (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_done  (ev_done[g]),
            .ev_mem   (ev_mem[g]),
            .rel_self (rel[g]),
            .gets_pkt (gets[g]),
            .mem_back (mem_back[g]),
            .grant    (grant[g]),
            .st_q     (st[g]),
            .want     (want[g])
        );
    end

    // registered pulses and round-robin pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= TIDW'(NTHR - 1);
            acc_q  <= 1'b0;
            exit_q <= 1'b0;
            mi_q   <= 1'b0;
            mit_q  <= '0;
        end else begin
            if (gnt_valid) begin
                last_q <= gnt_idx;
            end
            acc_q  <= accept;
            exit_q <= rel[NTHR-1];
            mi_q   <= |ev_mem;
            if (|ev_mem) begin
                mit_q <= act_tid;
            end
        end
    end

    assign pkt_accept    = acc_q;
    assign chain_exit    = exit_q;
    assign mem_issue     = mi_q;
    assign mem_issue_tid = mit_q;

    a_r2_one_active: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_vec) <= 1);
    a_r3_ready_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        (|rdy_vec) |-> (|act_vec));
    a_r8_last_never_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_vec[NTHR-1]);
    a_r4_accept_fills_first: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_accept |-> (st[0] == TS_ACTIVE || st[0] == TS_READY));
    a_r5_issue_waits: assert property (@(posedge clk) disable iff (!rst_n)
        mem_issue |-> (st[mem_issue_tid] == TS_MEMWAIT));

    for (genvar g = 0; g < NTHR - 1; g++) begin : g_blkchk
        a_r8_blocked_succ_busy: assert property (@(posedge clk) disable iff (!rst_n)
            blk_vec[g] |-> (st[g+1] != TS_IDLE));
    end

endmodule

// File: tb/test_pkt_thread_sched.sv
`timescale 1ns/1ps
module test_pkt_thread_sched;

    localparam int NT = 4;
    localparam int TW = 2;

    typedef struct packed {
        logic [NT*3-1:0] st;
        logic            av;
        logic [TW-1:0]   at;
        logic            acc;
        logic            ex;
        logic            mi;
        logic [TW-1:0]   mit;
    } snap_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pkt_arrive = 1'b0;
    logic [NT-1:0]   mem_req = '0;
    logic [NT-1:0]   proc_done = '0;
    logic            mem_cpl_valid = 1'b0;
    logic [TW-1:0]   mem_cpl_tid = '0;
    logic [NT*3-1:0] thr_status;
    logic            act_valid;
    logic [TW-1:0]   act_tid;
    logic            pkt_accept;
    logic            chain_exit;
    logic            mem_issue;
    logic [TW-1:0]   mem_issue_tid;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    snap_t exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    pkt_thread_sched #(.NTHR(NT)) i_pkt_thread_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .pkt_arrive    (pkt_arrive),
        .mem_req       (mem_req),
        .proc_done     (proc_done),
        .mem_cpl_valid (mem_cpl_valid),
        .mem_cpl_tid   (mem_cpl_tid),
        .thr_status    (thr_status),
        .act_valid     (act_valid),
        .act_tid       (act_tid),
        .pkt_accept    (pkt_accept),
        .chain_exit    (chain_exit),
        .mem_issue     (mem_issue),
        .mem_issue_tid (mem_issue_tid)
    );

    function automatic logic [NT*3-1:0] pk(input int s0, input int s1, input int s2, input int s3);
        return {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
    endfunction

    function automatic snap_t observe();
        snap_t a;
        a.st  = thr_status;
        a.av  = act_valid;
        a.at  = act_tid;
        a.acc = pkt_accept;
        a.ex  = chain_exit;
        a.mi  = mem_issue;
        a.mit = mem_issue ? mem_issue_tid : '0;
        return a;
    endfunction

    task automatic compare(input snap_t e, input string tag);
        snap_t a;
        a = observe();
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual st=%h av=%b at=%0d acc=%b ex=%b mi=%b mit=%0d expected st=%h av=%b at=%0d acc=%b ex=%b mi=%b mit=%0d",
                     tag, a.st, a.av, a.at, a.acc, a.ex, a.mi, a.mit,
                     e.st, e.av, e.at, e.acc, e.ex, e.mi, e.mit);
        end
    endtask

    // driver: apply stimulus on a falling edge, queue the expected result
    task automatic step(input logic arr, input logic [NT-1:0] mr, input logic [NT-1:0] dn,
                        input logic cv, input logic [TW-1:0] ct,
                        input logic [NT*3-1:0] est, input logic eacc, input logic eex,
                        input logic emi, input logic [TW-1:0] emit, input string tag);
        snap_t e;
        @(negedge clk);
        pkt_arrive    = arr;
        mem_req       = mr;
        proc_done     = dn;
        mem_cpl_valid = cv;
        mem_cpl_tid   = ct;
        e.st  = est;
        e.av  = 1'b0;
        e.at  = '0;
        for (int j = 0; j < NT; j++) begin
            if (est[j*3 +: 3] == 3'd1) begin
                e.av = 1'b1;
                e.at = TW'(j);
            end
        end
        e.acc = eacc;
        e.ex  = eex;
        e.mi  = emi;
        e.mit = emi ? emit : '0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: one quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            snap_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compare(e, t);
        end
    end

    initial begin
        snap_t z;
        z = '0;
        repeat (3) @(negedge clk);
        compare(z, "R1 reset state");
        rst_n = 1'b1;

        step(1, 4'b0000, 4'b0000, 0, 0, pk(1,0,0,0), 1, 0, 0, 0, "R4 accept into empty slot");
        step(1, 4'b0000, 4'b0000, 0, 0, pk(1,0,0,0), 0, 0, 0, 0, "R4 refused when thread0 busy");
        step(0, 4'b0000, 4'b0001, 0, 0, pk(0,1,0,0), 0, 0, 0, 0, "R7 hand-off to idle successor");
        step(1, 4'b0000, 4'b0000, 0, 0, pk(3,1,0,0), 1, 0, 0, 0, "R4 accept into ready");
        step(0, 4'b0001, 4'b0001, 0, 0, pk(3,1,0,0), 0, 0, 0, 0, "R11 strobes of ready thread ignored");
        step(0, 4'b0010, 4'b0000, 0, 0, pk(1,2,0,0), 0, 0, 1, 1, "R5 R3 memory request and promotion");
        step(0, 4'b0001, 4'b0000, 0, 0, pk(2,2,0,0), 0, 0, 1, 0, "R5 second request");
        step(0, 4'b0000, 4'b0000, 1, 0, pk(2,2,0,0), 0, 0, 0, 0, "R6 out-of-order completion ignored");
        step(0, 4'b0000, 4'b0000, 1, 1, pk(2,1,0,0), 0, 0, 0, 0, "R6 completion into free slot");
        step(0, 4'b0010, 4'b0010, 0, 0, pk(2,0,1,0), 0, 0, 0, 0, "R5 done wins over request");
        step(0, 4'b0000, 4'b0000, 1, 0, pk(3,0,1,0), 0, 0, 0, 0, "R6 completion to ready");
        step(0, 4'b0000, 4'b0100, 0, 0, pk(3,0,0,1), 0, 0, 0, 0, "R10 round-robin after last active");
        step(0, 4'b0000, 4'b1000, 0, 0, pk(1,0,0,0), 0, 1, 0, 0, "R7 chain exit from last thread");
        step(0, 4'b0000, 4'b0001, 0, 0, pk(0,1,0,0), 0, 0, 0, 0, "R7 hand-off");
        step(1, 4'b0000, 4'b0000, 0, 0, pk(3,1,0,0), 1, 0, 0, 0, "R4 accept into ready");
        step(0, 4'b0000, 4'b0010, 0, 0, pk(3,0,1,0), 0, 0, 0, 0, "R10 successor wins over thread0");
        step(0, 4'b0100, 4'b0000, 0, 0, pk(1,0,2,0), 0, 0, 1, 2, "R5 request from thread2");
        step(0, 4'b0000, 4'b0001, 0, 0, pk(0,1,2,0), 0, 0, 0, 0, "R7 hand-off");
        step(1, 4'b0000, 4'b0000, 0, 0, pk(3,1,2,0), 1, 0, 0, 0, "R4 accept into ready");
        step(0, 4'b0000, 4'b0010, 0, 0, pk(1,4,2,0), 0, 0, 0, 0, "R8 block behind waiting successor");
        step(0, 4'b0000, 4'b0001, 0, 0, pk(4,4,2,0), 0, 0, 0, 0, "R8 block behind blocked successor");
        step(1, 4'b0000, 4'b0000, 0, 0, pk(4,4,2,0), 0, 0, 0, 0, "R4 refused when thread0 blocked");
        step(0, 4'b0000, 4'b0000, 1, 2, pk(4,4,1,0), 0, 0, 0, 0, "R6 completion resumes thread2");
        step(0, 4'b0000, 4'b0100, 0, 0, pk(0,3,3,1), 0, 0, 0, 0, "R9 cascade release");
        step(1, 4'b0000, 4'b1000, 0, 0, pk(1,3,3,0), 1, 1, 0, 0, "R10 R7 wrap to thread0 with exit");
        step(0, 4'b0000, 4'b0001, 0, 0, pk(4,1,3,0), 0, 0, 0, 0, "R8 block behind ready successor");
        step(0, 4'b0000, 4'b0010, 0, 0, pk(4,4,1,0), 0, 0, 0, 0, "R8 second block");
        step(0, 4'b0000, 4'b0100, 0, 0, pk(0,3,3,1), 0, 0, 0, 0, "R9 cascade release again");
        step(0, 4'b0000, 4'b0000, 0, 0, pk(0,3,3,1), 0, 0, 0, 0, "R2 state holds without events");

        @(negedge clk);
        pkt_arrive = 1'b0; mem_req = '0; proc_done = '0; mem_cpl_valid = 1'b0;
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule